// File: doc/BRIEF.md
# Coprocessor Handshake Sequencer

This block walks a core through one coprocessor instruction. Once an instruction is accepted, the block checks the permission flag. It then offers the coprocessor a sequence of phase codes and acts on each response code the coprocessor returns in the same cycle. An operation can be one of five kinds:

- a register move into the coprocessor
- a register move out of the coprocessor
- an internal data operation
- a multi-word load from memory into the coprocessor
- a multi-word store from the coprocessor to memory

While the coprocessor reports that it is busy, the sequencer waits. In each idle wait cycle it looks at the reset, fast-interrupt and normal-interrupt lines. A pending event makes it abandon the instruction.

Memory operations stream one word per cycle. The address rises by one word for as long as the coprocessor asks for more. A memory abort stops the stream. At completion the block gives a single-cycle done pulse, which carries the outcome: an undefined-instruction exception, a memory-abort exception, an interrupt-taken flag with its source, or a base-writeback enable. The address of the last word moved stays visible after completion.

Top module: `cp_handshake_seq`

## Requirements
- R1: A start seen in idle with `perm_ok` low produces `done` and `undef_exc` in the next cycle; `cp_phase` stays 0 (none) throughout.
- R2: Phase codes are 0 none, 1 first, 2 busy, 3 interrupt, 4 transfer, 5 data. Response codes are 0 done, 1 busy, 2 cant, 3 inc. The first phase appears in the cycle after an accepted start. A busy response to a first or busy phase is followed by one cycle with no phase, and then a busy phase.
- R3: If an interrupt is pending in that idle wait cycle, the next cycle carries the interrupt phase. The cycle after that has `done` and `intr_taken` high, with no further phases.
- R4: Interrupt pending priority: `rst_line_n` low gives kind 1. Otherwise `fiq_n` low with `fmask` low gives kind 2. Otherwise `irq_n` low with `imask` low gives kind 3. A low line whose mask is high is not pending.
- R5: A cant response to a first or busy phase produces `done` with `undef_exc` in the next cycle.
- R6: Operation codes are 0 to-coprocessor, 1 from-coprocessor, 2 data operation, 3 load, 4 store. After the go response (done or inc), a load issues the transfer phase and then data phases. A store goes straight to data phases with `mem_we` high. Each data phase asserts `mem_req` at `mem_addr`.
- R7: The first data phase uses `base_addr`. Each inc response without an abort moves the next data phase 4 bytes higher. After `done`, `final_addr` holds the address of the last word moved.
- R8: `mem_abort` during a data phase ends the stream. The next cycle has `done` with `abort_exc`, whatever the response was.
- R9: `wb_en` rises with `done` after a memory operation whose `wb_bit` was set. The exception is an aborted operation with `late_abt` low, where it stays low.
- R10: After the go response, a to-coprocessor move or data operation reports `done` 2 cycles later. A from-coprocessor move reports `done` 3 cycles later.
- R11: `start` is ignored outside idle. `done` and each outcome flag last exactly one cycle, and at most one exception flag is high at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request to begin an instruction |
| op | input | 3 | Operation code |
| perm_ok | input | 1 | Access permission for the addressed coprocessor |
| wb_bit | input | 1 | Instruction asks for base writeback |
| late_abt | input | 1 | Late-abort mode |
| base_addr | input | AW | First memory word address |
| cp_phase | output | 3 | Phase code offered to the coprocessor |
| cp_resp | input | 2 | Coprocessor response, same cycle |
| cp_rdata | output | DW | Loaded word passed to the coprocessor |
| cp_wdata | input | DW | Word from the coprocessor for stores |
| mem_req | output | 1 | Memory word access |
| mem_we | output | 1 | Memory write |
| mem_addr | output | AW | Memory word address |
| mem_wdata | output | DW | Store data |
| mem_rdata | input | DW | Load data |
| mem_abort | input | 1 | Memory abort, same cycle |
| rst_line_n | input | 1 | Core reset request, active low |
| fiq_n | input | 1 | Fast interrupt, active low |
| irq_n | input | 1 | Normal interrupt, active low |
| fmask | input | 1 | Fast interrupt disabled |
| imask | input | 1 | Normal interrupt disabled |
| undef_exc | output | 1 | Undefined-instruction exception |
| abort_exc | output | 1 | Memory abort exception |
| intr_taken | output | 1 | Instruction abandoned for an interrupt |
| intr_kind | output | 2 | Source of the abandoning event |
| wb_en | output | 1 | Base writeback enable |
| final_addr | output | AW | Address of the last word moved |
| done | output | 1 | Completion pulse |

## Verification
Phases and memory strobes depend only on state, so they are due in the cycle after the response that selects them. Every outcome flag, and `done`, is registered and shows one cycle after the deciding response or memory abort. The bench turns each scenario into an expected trace, one entry per clock after the start edge. At every falling edge it compares every output with the trace and applies that entry's response, abort and interrupt lines. A response is therefore never checked or driven a cycle early or late.

// File: rtl/cphs_pkg.sv
package cphs_pkg;
  localparam logic [2:0] PH_NONE  = 3'd0;
  localparam logic [2:0] PH_FIRST = 3'd1;
  localparam logic [2:0] PH_BUSY  = 3'd2;
  localparam logic [2:0] PH_INTR  = 3'd3;
  localparam logic [2:0] PH_XFER  = 3'd4;
  localparam logic [2:0] PH_DATA  = 3'd5;

  localparam logic [1:0] RS_DONE = 2'd0;
  localparam logic [1:0] RS_BUSY = 2'd1;
  localparam logic [1:0] RS_CANT = 2'd2;
  localparam logic [1:0] RS_INC  = 2'd3;

  localparam logic [2:0] OP_TO_CP   = 3'd0;
  localparam logic [2:0] OP_FROM_CP = 3'd1;
  localparam logic [2:0] OP_DATA    = 3'd2;
  localparam logic [2:0] OP_LOAD    = 3'd3;
  localparam logic [2:0] OP_STORE   = 3'd4;

  typedef enum logic [3:0] {
    S_IDLE, S_FIRST, S_WAIT, S_BUSY, S_INTR, S_XFER, S_DATA, S_CCYC, S_ICYC
  } seq_state_e;

  function automatic logic [2:0] phase_of(seq_state_e s);
    case (s)
      S_FIRST: return PH_FIRST;
      S_BUSY:  return PH_BUSY;
      S_INTR:  return PH_INTR;
      S_XFER:  return PH_XFER;
      S_DATA:  return PH_DATA;
      default: return PH_NONE;
    endcase
  endfunction

  function automatic logic wb_allowed(logic want, logic aborted, logic late);
    return want && (!aborted || late);
  endfunction
endpackage

// File: rtl/cphs_pend_arb.sv
module cphs_pend_arb (
  input  logic       rst_line_n,
  input  logic       fiq_n,
  input  logic       irq_n,
  input  logic       fmask,
  input  logic       imask,
  output logic       pend,
  output logic [1:0] kind
);
  always_comb begin
    pend = 1'b1;
    kind = 2'd1;
    if (!rst_line_n) begin
      kind = 2'd1;
    end else if (!fiq_n && !fmask) begin
      kind = 2'd2;
    end else if (!irq_n && !imask) begin
      kind = 2'd3;
    end else begin
      pend = 1'b0;
      kind = 2'd0;
    end
  end
endmodule

// File: rtl/cphs_addr_gen.sv
module cphs_addr_gen #(
  parameter int AW = 32,
  parameter int WORD_BYTES = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          step,
  input  logic [AW-1:0] base,
  output logic [AW-1:0] addr
);
  localparam logic [AW-1:0] STRIDE = AW'(WORD_BYTES);

  always_ff @(posedge clk) begin
    if (!rst_n)     addr <= '0;
    else if (load)  addr <= base;
    else if (step)  addr <= addr + STRIDE;
  end
endmodule

// File: rtl/cp_handshake_seq.sv
module cp_handshake_seq #(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int WORD_BYTES = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [2:0]    op,
  input  logic          perm_ok,
  input  logic          wb_bit,
  input  logic          late_abt,
  input  logic [AW-1:0] base_addr,
  output logic [2:0]    cp_phase,
  input  logic [1:0]    cp_resp,
  output logic [DW-1:0] cp_rdata,
  input  logic [DW-1:0] cp_wdata,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  input  logic          mem_abort,
  input  logic          rst_line_n,
  input  logic          fiq_n,
  input  logic          irq_n,
  input  logic          fmask,
  input  logic          imask,
  output logic          undef_exc,
  output logic          abort_exc,
  output logic          intr_taken,
  output logic [1:0]    intr_kind,
  output logic          wb_en,
  output logic [AW-1:0] final_addr,
  output logic          done
);
  import cphs_pkg::*;

  seq_state_e state, nxt;
  logic [2:0] op_q;
  logic       wb_q, late_q;
  logic       addr_load, addr_step;
  logic       fin, f_undef, f_abort, f_intr, f_wb;
  logic       irq_pend;
  logic [1:0] pend_kind;
  logic [AW-1:0] addr;

  // named events for the checker
  logic seq_idle, seq_wait;
  assign seq_idle = (state == S_IDLE);
  assign seq_wait = (state == S_WAIT);

  cphs_pend_arb u_arb (
    .rst_line_n(rst_line_n), .fiq_n(fiq_n), .irq_n(irq_n),
    .fmask(fmask), .imask(imask), .pend(irq_pend), .kind(pend_kind)
  );

  cphs_addr_gen #(.AW(AW), .WORD_BYTES(WORD_BYTES)) u_addr (
    .clk(clk), .rst_n(rst_n), .load(addr_load), .step(addr_step),
    .base(base_addr), .addr(addr)
  );

  always_comb begin
    nxt = state;
    fin = 1'b0; f_undef = 1'b0; f_abort = 1'b0; f_intr = 1'b0; f_wb = 1'b0;
    addr_load = 1'b0; addr_step = 1'b0;
    case (state)
      S_IDLE: if (start) begin
        addr_load = 1'b1;
        if (!perm_ok) begin fin = 1'b1; f_undef = 1'b1; end
        else nxt = S_FIRST;
      end
      S_FIRST, S_BUSY: begin
        if (cp_resp == RS_BUSY) nxt = S_WAIT;
        else if (cp_resp == RS_CANT) begin
          fin = 1'b1; f_undef = 1'b1; nxt = S_IDLE;
        end else if (op_q == OP_LOAD)  nxt = S_XFER;
        else if (op_q == OP_STORE) nxt = S_DATA;
        else nxt = S_CCYC;
      end
      S_WAIT: nxt = irq_pend ? S_INTR : S_BUSY;
      S_INTR: begin fin = 1'b1; f_intr = 1'b1; nxt = S_IDLE; end
      S_XFER: nxt = S_DATA;
      S_DATA: begin
        if (mem_abort) begin
          fin = 1'b1; f_abort = 1'b1; nxt = S_IDLE;
          f_wb = wb_allowed(wb_q, 1'b1, late_q);
        end else if (cp_resp == RS_INC) begin
          addr_step = 1'b1;
        end else begin
          fin = 1'b1; nxt = S_IDLE;
          f_wb = wb_allowed(wb_q, 1'b0, late_q);
        end
      end
      S_CCYC: if (op_q == OP_FROM_CP) nxt = S_ICYC;
              else begin fin = 1'b1; nxt = S_IDLE; end
      S_ICYC: begin fin = 1'b1; nxt = S_IDLE; end
      default: nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= S_IDLE;
      op_q <= '0; wb_q <= 1'b0; late_q <= 1'b0;
      done <= 1'b0; undef_exc <= 1'b0; abort_exc <= 1'b0;
      intr_taken <= 1'b0; wb_en <= 1'b0; intr_kind <= '0;
    end else begin
      state <= nxt;
      if (seq_idle && start) begin
        op_q <= op; wb_q <= wb_bit; late_q <= late_abt;
      end
      if (seq_wait) intr_kind <= pend_kind;
      done       <= fin;
      undef_exc  <= f_undef;
      abort_exc  <= f_abort;
      intr_taken <= f_intr;
      wb_en      <= f_wb;
    end
  end

  assign cp_phase   = phase_of(state);
  assign mem_req    = (state == S_DATA);
  assign mem_we     = mem_req && (op_q == OP_STORE);
  assign mem_addr   = addr;
  assign final_addr = addr;
  assign cp_rdata   = mem_rdata;
  assign mem_wdata  = cp_wdata;
endmodule

// File: rtl/cphs_checker.sv
module cphs_checker #(
  parameter int AW = 32,
  parameter int WORD_BYTES = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          perm_ok,
  input logic          late_abt,
  input logic          seq_idle,
  input logic          seq_wait,
  input logic          irq_pend,
  input logic [2:0]    cp_phase,
  input logic [1:0]    cp_resp,
  input logic          mem_abort,
  input logic [AW-1:0] mem_addr,
  input logic          done,
  input logic          undef_exc,
  input logic          abort_exc,
  input logic          intr_taken,
  input logic          wb_en
);
  import cphs_pkg::*;

  a_r1_denied_no_phase: assert property (@(posedge clk) disable iff (!rst_n)
    start && seq_idle && !perm_ok |=> done && undef_exc && cp_phase == PH_NONE);

  a_r2_idle_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (cp_phase == PH_FIRST || cp_phase == PH_BUSY) && cp_resp == RS_BUSY
    |=> cp_phase == PH_NONE && !done);

  a_r3_abandon_phase: assert property (@(posedge clk) disable iff (!rst_n)
    seq_wait && irq_pend |=> cp_phase == PH_INTR);

  a_r3_abandon_done: assert property (@(posedge clk) disable iff (!rst_n)
    cp_phase == PH_INTR |=> done && intr_taken);

  a_r5_cant_undef: assert property (@(posedge clk) disable iff (!rst_n)
    (cp_phase == PH_FIRST || cp_phase == PH_BUSY) && cp_resp == RS_CANT
    |=> done && undef_exc);

  a_r7_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
    cp_phase == PH_DATA && cp_resp == RS_INC && !mem_abort
    |=> cp_phase == PH_DATA && mem_addr == $past(mem_addr) + AW'(WORD_BYTES));

  a_r8_abort_stop: assert property (@(posedge clk) disable iff (!rst_n)
    cp_phase == PH_DATA && mem_abort |=> done && abort_exc && cp_phase == PH_NONE);

  a_r9_no_wb_early_abort: assert property (@(posedge clk) disable iff (!rst_n)
    cp_phase == PH_DATA && mem_abort && !late_abt |=> !wb_en);

  a_r11_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r11_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({undef_exc, abort_exc, intr_taken}));
endmodule

bind cp_handshake_seq cphs_checker #(.AW(AW), .WORD_BYTES(WORD_BYTES)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .perm_ok(perm_ok), .late_abt(late_abt),
  .seq_idle(seq_idle), .seq_wait(seq_wait), .irq_pend(irq_pend),
  .cp_phase(cp_phase), .cp_resp(cp_resp), .mem_abort(mem_abort), .mem_addr(mem_addr),
  .done(done), .undef_exc(undef_exc), .abort_exc(abort_exc),
  .intr_taken(intr_taken), .wb_en(wb_en)
);

// File: tb/cp_handshake_seq_bench.sv
module cp_handshake_seq_bench;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic [2:0]  ph;
    logic        req;
    logic        we;
    logic [31:0] addr;
    logic [1:0]  resp;
    logic        abt;
    logic [4:0]  lines;  // {rst_line_n, fiq_n, irq_n, fmask, imask}
    logic        dn, und, abo, itk;
    logic [1:0]  kind;
    logic        wb;
    logic        cfa;
    logic [31:0] fa;
  } rec_t;

  localparam logic [4:0] LINES_QUIET = 5'b11100;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [2:0] op = '0;
  logic perm_ok = 1'b0, wb_bit = 1'b0, late_abt = 1'b0;
  logic [31:0] base_addr = '0;
  logic [2:0] cp_phase;
  logic [1:0] cp_resp = '0;
  logic [31:0] cp_rdata, cp_wdata = 32'hA5A5_0001, mem_wdata, mem_rdata = 32'h5A5A_0002;
  logic mem_req, mem_we, mem_abort = 1'b0;
  logic [31:0] mem_addr, final_addr;
  logic rst_line_n = 1'b1, fiq_n = 1'b1, irq_n = 1'b1, fmask = 1'b0, imask = 1'b0;
  logic undef_exc, abort_exc, intr_taken, wb_en, done;
  logic [1:0] intr_kind;

  int n_chk = 0, n_bad = 0;
  bit finished = 0;
  rec_t q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  cp_handshake_seq u_cp_handshake_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op), .perm_ok(perm_ok),
    .wb_bit(wb_bit), .late_abt(late_abt), .base_addr(base_addr),
    .cp_phase(cp_phase), .cp_resp(cp_resp), .cp_rdata(cp_rdata), .cp_wdata(cp_wdata),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_abort(mem_abort),
    .rst_line_n(rst_line_n), .fiq_n(fiq_n), .irq_n(irq_n), .fmask(fmask), .imask(imask),
    .undef_exc(undef_exc), .abort_exc(abort_exc), .intr_taken(intr_taken),
    .intr_kind(intr_kind), .wb_en(wb_en), .final_addr(final_addr), .done(done)
  );

  task automatic chk(string tag, string what, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual %0h expected %0h", tag, what, got, exp);
    end
  endtask

  function automatic rec_t blank();
    rec_t r = '0;
    r.lines = LINES_QUIET;
    return r;
  endfunction

  // interrupt scenario codes: line pattern and the kind that should win (0 = none)
  function automatic logic [4:0] lines_of(int m);
    case (m)
      1: return 5'b01100; 2: return 5'b10100; 3: return 5'b11000;
      4: return 5'b10011; 5: return 5'b00000; 6: return 5'b10000;
      7: return 5'b10010; default: return LINES_QUIET;
    endcase
  endfunction
  function automatic logic [1:0] winner(int m);
    case (m)
      1, 5: return 2'd1; 2, 6: return 2'd2; 3, 7: return 2'd3;
      default: return 2'd0;
    endcase
  endfunction

  function automatic void build(logic [2:0] o, bit perm, bit wbb, bit late,
                                logic [31:0] base, int nbusy, int int_at, int imode,
                                logic [1:0] fin_resp, int n_inc, int abort_at);
    rec_t r;
    q.delete();
    if (!perm) begin r = blank(); r.dn = 1; r.und = 1; q.push_back(r); return; end
    r = blank(); r.ph = 3'd1; r.resp = (nbusy > 0) ? 2'd1 : fin_resp; q.push_back(r);
    for (int b = 0; b < nbusy; b++) begin
      r = blank();
      if (b == int_at) r.lines = lines_of(imode);
      q.push_back(r);
      if (b == int_at && winner(imode) != 0) begin
        r = blank(); r.ph = 3'd3; q.push_back(r);
        r = blank(); r.dn = 1; r.itk = 1; r.kind = winner(imode); q.push_back(r);
        return;
      end
      r = blank(); r.ph = 3'd2; r.resp = (b < nbusy - 1) ? 2'd1 : fin_resp; q.push_back(r);
    end
    if (fin_resp == 2'd2) begin r = blank(); r.dn = 1; r.und = 1; q.push_back(r); return; end
    if (o == 3'd3 || o == 3'd4) begin
      if (o == 3'd3) begin r = blank(); r.ph = 3'd4; q.push_back(r); end
      for (int w = 0; w <= n_inc; w++) begin
        r = blank(); r.ph = 3'd5; r.req = 1; r.we = (o == 3'd4);
        r.addr = base + 32'(4 * w);
        r.resp = (w < n_inc) ? 2'd3 : 2'd0;
        r.abt = (w == abort_at);
        q.push_back(r);
        if (w == abort_at || w == n_inc) begin
          rec_t e = blank();
          e.dn = 1; e.cfa = 1; e.fa = r.addr;
          e.abo = (w == abort_at);
          e.wb = wbb && (!e.abo || late);
          q.push_back(e);
          return;
        end
      end
    end else begin
      r = blank(); q.push_back(r);
      if (o == 3'd1) q.push_back(r);
      r.dn = 1; q.push_back(r);
    end
  endfunction

  task automatic run(string tag, logic [2:0] o, bit perm, bit wbb, bit late,
                     logic [31:0] base, int nbusy, int int_at, int imode,
                     logic [1:0] fin_resp, int n_inc, int abort_at, bit hold);
    build(o, perm, wbb, late, base, nbusy, int_at, imode, fin_resp, n_inc, abort_at);
    @(negedge clk);
    start = 1; op = o; perm_ok = perm; wb_bit = wbb; late_abt = late; base_addr = base;
    foreach (q[i]) begin
      @(negedge clk);
      if (!hold || q[i].dn) start = 0;
      chk(tag, "phase", 32'(cp_phase), 32'(q[i].ph));
      chk(tag, "mem_req", 32'(mem_req), 32'(q[i].req));
      chk(tag, "mem_we", 32'(mem_we), 32'(q[i].we));
      if (q[i].req) chk(tag, "mem_addr", mem_addr, q[i].addr);
      if (q[i].req && q[i].we) chk(tag, "mem_wdata", mem_wdata, cp_wdata);
      chk(tag, "done", 32'(done), 32'(q[i].dn));
      chk(tag, "undef", 32'(undef_exc), 32'(q[i].und));
      chk(tag, "abort", 32'(abort_exc), 32'(q[i].abo));
      chk(tag, "intr", 32'(intr_taken), 32'(q[i].itk));
      chk(tag, "wb", 32'(wb_en), 32'(q[i].wb));
      if (q[i].itk) chk(tag, "kind", 32'(intr_kind), 32'(q[i].kind));
      if (q[i].cfa) chk(tag, "final_addr", final_addr, q[i].fa);
      cp_resp = q[i].resp; mem_abort = q[i].abt;
      {rst_line_n, fiq_n, irq_n, fmask, imask} = q[i].lines;
    end
    @(negedge clk);
    start = 0; cp_resp = 0; mem_abort = 0;
    {rst_line_n, fiq_n, irq_n, fmask, imask} = LINES_QUIET;
    chk(tag, "idle phase", 32'(cp_phase), 32'd0);
    chk(tag, "done drop", 32'(done), 32'd0);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual running expected finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R11 reset state
    chk("R11", "reset phase", 32'(cp_phase), 32'd0);
    chk("R11", "reset done", 32'(done), 32'd0);
    chk("R11", "reset mem_req", 32'(mem_req), 32'd0);
    // R1 permission denied
    run("R1", 3'd3, 0, 1, 0, 32'h100, 0, -1, 0, 2'd0, 0, -1, 0);
    // R2 R10 to-coprocessor, no wait
    run("R10", 3'd0, 1, 0, 0, 32'h0, 0, -1, 0, 2'd0, 0, -1, 0);
    // R2 R10 from-coprocessor after two busy answers
    run("R2", 3'd1, 1, 0, 0, 32'h0, 2, -1, 0, 2'd0, 0, -1, 0);
    // R3 R4 normal interrupt abandons a data operation
    run("R3", 3'd2, 1, 0, 0, 32'h0, 2, 0, 3, 2'd0, 0, -1, 0);
    // R4 reset wins over everything
    run("R4", 3'd2, 1, 0, 0, 32'h0, 3, 1, 5, 2'd0, 0, -1, 0);
    // R4 fast over normal
    run("R4", 3'd1, 1, 0, 0, 32'h0, 1, 0, 6, 2'd0, 0, -1, 0);
    // R4 masked lines are not pending
    run("R4", 3'd0, 1, 0, 0, 32'h0, 1, 0, 4, 2'd0, 0, -1, 0);
    // R4 masked fast, unmasked normal
    run("R4", 3'd2, 1, 0, 0, 32'h0, 2, 1, 7, 2'd0, 0, -1, 0);
    // R5 cant after a busy
    run("R5", 3'd0, 1, 0, 0, 32'h0, 1, -1, 0, 2'd2, 0, -1, 0);
    // R5 cant on first phase of a store
    run("R5", 3'd4, 1, 1, 0, 32'h40, 0, -1, 0, 2'd2, 0, -1, 0);
    // R6 R7 R9 load of four words with writeback
    run("R7", 3'd3, 1, 1, 0, 32'h1000, 0, -1, 0, 2'd0, 3, -1, 0);
    // R6 R11 store of three words, start held high throughout
    run("R11", 3'd4, 1, 0, 0, 32'h2000, 0, -1, 0, 2'd0, 2, -1, 1);
    // R8 R9 abort on second load word, late mode off
    run("R9", 3'd3, 1, 1, 0, 32'h3000, 0, -1, 0, 2'd0, 3, 1, 0);
    // R8 R9 abort on first store word, late mode on
    run("R8", 3'd4, 1, 1, 1, 32'h4000, 1, -1, 0, 2'd0, 2, 0, 0);
    // R6 R7 load crossing the address wrap after busy waits
    run("R6", 3'd3, 1, 0, 0, 32'hFFFF_FFF8, 2, -1, 0, 2'd0, 2, -1, 0);
    finish_run();
  end
endmodule